// File: doc/BRIEF.md
# Nonvolatile Image Checksum Sequencer

This block walks the word-read and word-write port of a nonvolatile memory controller to check or repair an additive 16-bit image checksum. An image is valid when all of its words, from address zero up to and including a dedicated checksum word, add up to the fixed value 0xBABA. The adds wrap modulo 65536.

A caller pulses `start` and selects one of two operations on `mode`.

- **Check operation:** reads every word of the image, including the checksum word. It reports through `error` whether the total missed the signature.
- **Repair operation:** reads every word below the checksum word. It then writes the value that brings the total to the signature into the checksum word.

Only one memory request is outstanding at any time. The engine holds a request until the controller answers with its acknowledge. A fault flagged by the controller on a read ends the sequence at once. A fault on the write ends the sequence with an error.

Top module: `nvm_csum_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `error`, `mem_rd_req` and `mem_wr_req` are all low.
- R2: With `mode`=0 (check), the engine reads addresses 0 through CSUM_ADDR (default 63) in ascending order. It issues exactly CSUM_ADDR+1 reads and no write.
- R3: A check whose 16-bit wrapping total of all words read equals 0xBABA ends with `done` high and `error` low.
- R4: A check whose wrapping total differs from 0xBABA ends with `error` high.
- R5: With `mode`=1 (repair), the engine reads addresses 0 through CSUM_ADDR-1 in ascending order. It then issues one write to CSUM_ADDR carrying 0xBABA minus the wrapping sum of those words, and ends with `error` low when the write is acknowledged without fault.
- R6: A read acknowledged with `mem_err` high ends the sequence in the next cycle with `error` high. No further read is issued and no write is issued.
- R7: A repair write acknowledged with `mem_err` high ends with `error` high.
- R8: `busy` rises the cycle after an accepted `start` and falls in the same cycle that the one-cycle `done` pulse appears. A `start` seen while `busy` is high changes neither the operation in progress nor its result.
- R9: `mem_rd_req` and `mem_wr_req` are never high together. A request stays high, with a steady address, until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 1 | 0 = check image, 1 = repair checksum word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Result of the last operation; valid from `done`, held until next start |
| mem_rd_req | output | 1 | Word read request, held until acknowledge |
| mem_wr_req | output | 1 | Word write request, held until acknowledge |
| mem_addr | output | ADDR_W | Word address of the current request |
| mem_wdata | output | DATA_W | Write data for the checksum word |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Controller completion handshake for the current request |
| mem_err | input | 1 | Fault flag, valid with `mem_ack` |

## Verification
A corrupted running sum stays hidden until the sequence ends. It then shows as a wrong `error` verdict on a check, or as a wrong word written by a repair. The bench therefore compares the stored checksum word after every repair and cross-checks it with a following check.

An address counter that skips, repeats or overruns shows up sooner. The memory model sees the wrong address on the very next request, and the total number of reads per operation no longer matches.

A control state that mishandles a fault shows in the cycle after the faulting acknowledge. The symptoms are a stray write, an extra read, or a `done` pulse that is missing or repeated.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_t;

  localparam logic OP_CHECK  = 1'b0;
  localparam logic OP_REPAIR = 1'b1;

endpackage

// File: rtl/nvm_csum_datapath.sv
module nvm_csum_datapath #(
  parameter int          DATA_W    = 16,
  parameter int          ADDR_W    = 8,
  parameter int          CSUM_ADDR = 63,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add_en,
  input  logic              repair,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              last_word,
  output logic              total_match
);

  localparam logic [ADDR_W-1:0] LAST_CHECK  = ADDR_W'(CSUM_ADDR);
  localparam logic [ADDR_W-1:0] LAST_REPAIR = ADDR_W'(CSUM_ADDR - 1);
  localparam logic [DATA_W-1:0] SIG         = DATA_W'(SIGNATURE);

  logic [DATA_W-1:0] sum_q;
  logic [DATA_W-1:0] sum_after;

  assign sum_after   = sum_q + rdata;
  assign last_word   = (addr == (repair ? LAST_REPAIR : LAST_CHECK));
  assign total_match = (sum_after == SIG);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q <= '0;
      addr  <= '0;
      wdata <= '0;
    end else if (add_en) begin
      sum_q <= sum_after;
      addr  <= addr + 1'b1;
      wdata <= SIG - sum_after;
    end
  end

  // R2: the running sum changes only on a clear or an accepted word
  p_sum_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !add_en) |=> $stable(sum_q));

  // R5: the staged write word always complements the running sum
  p_wdata_pair_r5: assert property (@(posedge clk) disable iff (rst)
    $past(add_en) |-> (DATA_W'(wdata + sum_q) == SIG));

endmodule

// File: rtl/nvm_csum_ctrl.sv
module nvm_csum_ctrl
  import nvm_csum_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mode,
  input  logic ack,
  input  logic err,
  input  logic last_word,
  input  logic total_match,
  output logic clr,
  output logic add_en,
  output logic repair,
  output logic busy,
  output logic done,
  output logic error,
  output logic rd_req,
  output logic wr_req
);

  seq_state_t state;

  assign clr    = (state == ST_IDLE) && start;
  assign add_en = (state == ST_READ) && ack && !err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      repair <= OP_CHECK;
      busy   <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
      rd_req <= 1'b0;
      wr_req <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy   <= 1'b1;
            error  <= 1'b0;
            repair <= mode;
            rd_req <= 1'b1;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          if (ack) begin
            if (err) begin
              rd_req <= 1'b0;
              busy   <= 1'b0;
              done   <= 1'b1;
              error  <= 1'b1;
              state  <= ST_IDLE;
            end else if (last_word) begin
              rd_req <= 1'b0;
              if (repair == OP_REPAIR) begin
                wr_req <= 1'b1;
                state  <= ST_WRITE;
              end else begin
                busy  <= 1'b0;
                done  <= 1'b1;
                error <= !total_match;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_WRITE: begin
          if (ack) begin
            wr_req <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b1;
            error  <= err;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_ends_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(repair));

  p_abort_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ack && err) |=> (!wr_req && !rd_req && error && done));

  p_one_request_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
    ((rd_req || wr_req) && !ack) |=> (rd_req || wr_req));

endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine #(
  parameter int          DATA_W    = 16,
  parameter int          ADDR_W    = 8,
  parameter int          CSUM_ADDR = 63,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);

  logic clr, add_en, repair, last_word, total_match;

  nvm_csum_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mode        (mode),
    .ack         (mem_ack),
    .err         (mem_err),
    .last_word   (last_word),
    .total_match (total_match),
    .clr         (clr),
    .add_en      (add_en),
    .repair      (repair),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .rd_req      (mem_rd_req),
    .wr_req      (mem_wr_req)
  );

  nvm_csum_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CSUM_ADDR (CSUM_ADDR),
    .SIGNATURE (SIGNATURE)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .add_en      (add_en),
    .repair      (repair),
    .rdata       (mem_rdata),
    .addr        (mem_addr),
    .wdata       (mem_wdata),
    .last_word   (last_word),
    .total_match (total_match)
  );

  p_read_addr_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (int'(mem_addr) <= CSUM_ADDR));

  p_write_addr_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> (int'(mem_addr) == CSUM_ADDR));

  p_addr_steady_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_rd_req || mem_wr_req) && !$past(mem_ack)) |-> $stable(mem_addr));

endmodule

// File: tb/nvm_csum_engine_bench.sv
module nvm_csum_engine_bench;

  localparam int          CA  = 63;
  localparam logic [15:0] SIG = 16'hBABA;

  typedef struct {
    bit          err;
    int          nrd;
    int          nwr;
    logic [15:0] csum;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic        busy, done, error, rd_req, wr_req;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata = '0;
  logic        ack = 1'b0;
  logic        merr = 1'b0;

  logic [15:0] mem [0:CA];
  int   lat = 0;
  int   cnt = 0;
  int   fail_rd = -1;
  bit   fail_wr = 1'b0;
  int   nrd = 0, nwr = 0, rd_expect = 0;
  bit   order_bad = 1'b0;
  int   vectors = 0, miscompares = 0;
  int   cycles = 0;
  bit   prev_done = 1'b0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  nvm_csum_engine u_nvm_csum_engine (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .busy(busy), .done(done), .error(error),
    .mem_rd_req(rd_req), .mem_wr_req(wr_req), .mem_addr(addr),
    .mem_wdata(wdata), .mem_rdata(rdata), .mem_ack(ack), .mem_err(merr)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // memory controller model
  always @(posedge clk) begin
    ack  <= 1'b0;
    merr <= 1'b0;
    if (rst || !(rd_req || wr_req) || ack) begin
      cnt <= lat;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end else begin
      ack <= 1'b1;
      if (rd_req) begin
        rdata <= mem[addr[5:0]];
        if (int'(addr) != rd_expect) order_bad = 1'b1;
        rd_expect++;
        nrd++;
        if (int'(addr) == fail_rd) merr <= 1'b1;
      end else begin
        nwr++;
        if (int'(addr) != CA) order_bad = 1'b1;
        if (fail_wr) merr <= 1'b1;
        else mem[addr[5:0]] <= wdata;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) check(!done, "R8 done width", int'(done), 0);
      if (done) begin
        check(!busy, "R8 busy at done", int'(busy), 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(error == e.err, {e.tag, " error"}, int'(error), int'(e.err));
          check(nrd == e.nrd, {e.tag, " reads"}, nrd, e.nrd);
          check(nwr == e.nwr, {e.tag, " writes"}, nwr, e.nwr);
          check(mem[CA] == e.csum, {e.tag, " stored checksum"}, int'(mem[CA]), int'(e.csum));
          check(!order_bad, {e.tag, " R9 address order"}, int'(order_bad), 0);
        end
      end
      check(!(rd_req && wr_req), "R9 exclusive requests", int'(rd_req && wr_req), 0);
      prev_done = done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic exp_t predict(input bit m, input string tag);
    exp_t e;
    logic [15:0] s;
    int last;
    s = '0;
    e.tag = tag;
    e.nwr = 0;
    e.csum = mem[CA];
    last = m ? CA - 1 : CA;
    if (fail_rd >= 0 && fail_rd <= last) begin
      e.err = 1'b1;
      e.nrd = fail_rd + 1;
      return e;
    end
    for (int i = 0; i <= last; i++) s = s + mem[i];
    e.nrd = last + 1;
    if (!m) begin
      e.err = (s != SIG);
    end else begin
      e.nwr = 1;
      e.err = fail_wr;
      if (!fail_wr) e.csum = SIG - s;
    end
    return e;
  endfunction

  task automatic run_op(input bit m, input int latency, input string tag, input bit poke);
    exp_q.push_back(predict(m, tag));
    lat = latency;
    nrd = 0; nwr = 0; rd_expect = 0; order_bad = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; mode = ~m;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i <= CA; i++) mem[i] = 16'(i * 16'h1111 + 7);
    repeat (3) @(negedge clk);
    check(!busy && !done && !error, "R1 status after reset", int'({busy, done, error}), 0);
    check(!rd_req && !wr_req, "R1 requests after reset", int'({rd_req, wr_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !rd_req, "R1 idle after release", int'({busy, rd_req}), 0);

    run_op(1'b1, 0, "R5 repair pattern A", 1'b0);
    run_op(1'b0, 3, "R3 check after repair", 1'b0);
    mem[5] = mem[5] ^ 16'h0001;
    run_op(1'b0, 1, "R4 check corrupted", 1'b0);

    for (int i = 0; i <= CA; i++) mem[i] = (i % 2 == 0) ? 16'hFFFF : 16'hF00D;
    run_op(1'b1, 1, "R5 repair wrapping sum", 1'b0);
    run_op(1'b0, 2, "R2 check wrapping sum", 1'b0);

    fail_rd = 10;
    run_op(1'b0, 0, "R6 check read fault", 1'b0);
    fail_rd = 62;
    mem[0] = 16'h1234;
    run_op(1'b1, 2, "R6 repair read fault", 1'b0);
    fail_rd = -1;
    fail_wr = 1'b1;
    run_op(1'b1, 1, "R7 repair write fault", 1'b0);
    fail_wr = 1'b0;
    run_op(1'b0, 1, "R4 check after failed repair", 1'b0);
    run_op(1'b0, 2, "R8 start ignored while busy", 1'b1);
    run_op(1'b1, 0, "R5 repair second image", 1'b0);
    run_op(1'b0, 0, "R3 check second image", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule